// File: doc/BRIEF.md
# Brightness-Scaled Colour Scheme Mapper

This block turns a 2-bit display pixel code into three colour channel levels for a video DAC. A code either means black, a dim level or a full level. The full level equals a 10-bit brightness reading that an external ADC reader supplies. The dim level is half of that reading. The chosen intensity is cut down to the DAC resolution, which is set to 16 or 32 steps by a parameter. It is then sent to the red, green and blue channels that the active colour scheme enables for that intensity. Each scheme has its own channel set for the dim level and its own set for the full level.

Brightness and scheme changes take effect only at frame start, which is the rising edge of the vertical sync input. The brightness reading is sampled once per frame. A scheme request arrives as a code with a one-cycle strobe, for example from a remote-control decoder or from jumpers. The request is held until the next frame start, so no frame mixes two schemes or two brightness values. The colour outputs are registered, and the sync signals pass through one register stage so that they stay aligned with the colour outputs.

Top module: `pix_tint_mapper`

## Requirements
- R1: Pixel code 2'b00 drives all three channel outputs to zero one clock after it is presented, whatever the scheme and brightness.
- R2: Pixel code 2'b11 gives level `B >> (BRT_W - OUT_W)` on each channel enabled in the scheme's full-level mask, and zero on the other channels. B is the brightness captured at the last frame start.
- R3: Pixel codes 2'b01 and 2'b10 both give level `(B >> 1) >> (BRT_W - OUT_W)` on each channel enabled in the scheme's dim-level mask, and zero elsewhere.
- R4: The scheme masks, written as {red, green, blue}, are listed as (dim, full): scheme 0 is (010, 010), scheme 1 is (111, 111), scheme 2 is (110, 110), scheme 3 is (001, 111), scheme 4 is (010, 110) and scheme 5 is (011, 101).
- R5: A pixel presented in clock cycle t shows on red/grn/blu after the clock edge that ends cycle t. hsync_out and vsync_out carry hsync_in and vsync_in delayed by the same single register stage.
- R6: Frame start is a cycle in which vsync_in is high and was low in the previous cycle. The brightness input is captured only in that cycle and used for pixels from the next cycle onwards. Changes to brightness at any other time, including while vsync_in stays high, have no effect.
- R7: A sel_stb pulse with a sel_code below NUM_SCHEMES records a pending scheme. The pending scheme becomes active at the next frame start that occurs after the pulse cycle. A pulse in the frame-start cycle itself waits for the following frame start. A later pulse before that frame start replaces an earlier one.
- R8: A sel_stb pulse with sel_code of NUM_SCHEMES or more is ignored, and any earlier valid pending request is kept.
- R9: While rst_n is low, all outputs are zero. After reset, scheme 0 is active and the captured brightness is zero, so every pixel is black until the first frame start.
- R10: Parameter LVL_STEPS (16 or 32) sets the channel width OUT_W to log2(LVL_STEPS) bits. The level is the top OUT_W bits of the intensity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_code | input | 2 | Pixel code: black, dim or full |
| hsync_in | input | 1 | Horizontal sync that accompanies the pixel |
| vsync_in | input | 1 | Vertical sync; its rising edge marks frame start |
| brightness | input | BRT_W (10) | Live brightness reading |
| sel_stb | input | 1 | One-cycle strobe that requests a scheme |
| sel_code | input | SEL_W (3) | Index of the requested scheme |
| hsync_out | output | 1 | Horizontal sync delayed one cycle |
| vsync_out | output | 1 | Vertical sync delayed one cycle |
| red | output | OUT_W (5) | Red channel level |
| grn | output | OUT_W (5) | Green channel level |
| blu | output | OUT_W (5) | Blue channel level |

## Verification
The bench builds two copies of the block side by side from the same stimulus: one with the default 32 steps and one with LVL_STEPS set to 16. Every expected level is therefore checked both as a 5-bit and as a 4-bit value. This exercises the truncation boundaries, such as a brightness of 33 giving 1 at 32 steps and 0 at 16 steps. Both copies keep the default six schemes, so codes 6 and 7 are out of range and can test the rejection of invalid scheme requests. The 10-bit brightness width allows values of 1023 and 31, which cover the largest level and the point where the level truncates to zero.

// File: rtl/tint_pkg.sv
package tint_pkg;

  typedef enum logic [1:0] {
    PIX_BLACK = 2'b00,
    PIX_DIM_A = 2'b01,
    PIX_DIM_B = 2'b10,
    PIX_FULL  = 2'b11
  } pix_code_e;

  localparam int NUM_CH = 3;
  localparam int CH_RED = 2;
  localparam int CH_GRN = 1;
  localparam int CH_BLU = 0;

  typedef logic [NUM_CH-1:0] ch_mask_t;

  // Channel enable set {red, green, blue} for a scheme at dim or full level.
  function automatic ch_mask_t scheme_mask(input int unsigned idx, input logic full);
    case (idx)
      0:       return 3'b010;
      1:       return 3'b111;
      2:       return 3'b110;
      3:       return full ? 3'b111 : 3'b001;
      4:       return full ? 3'b110 : 3'b010;
      5:       return full ? 3'b101 : 3'b011;
      default: return 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/tint_frame_sched.sv
module tint_frame_sched #(
  parameter int BRT_W       = 10,
  parameter int NUM_SCHEMES = 6,
  parameter int SEL_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vsync_in,
  input  logic [BRT_W-1:0] brightness,
  input  logic             sel_stb,
  input  logic [SEL_W-1:0] sel_code,
  output logic             frame_start,
  output logic             sched_apply,
  output logic [SEL_W-1:0] cur_scheme,
  output logic [BRT_W-1:0] brt_q
);

  logic             vs_q;
  logic             pend_vld;
  logic [SEL_W-1:0] pend_sel;
  logic             sel_ok;

  assign frame_start = vsync_in && !vs_q;
  assign sched_apply = frame_start && pend_vld;
  assign sel_ok      = sel_stb && (32'(sel_code) < NUM_SCHEMES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q       <= 1'b0;
      brt_q      <= '0;
      cur_scheme <= '0;
      pend_sel   <= '0;
      pend_vld   <= 1'b0;
    end else begin
      vs_q <= vsync_in;
      if (frame_start) brt_q <= brightness;
      if (sched_apply) begin
        cur_scheme <= pend_sel;
        pend_vld   <= 1'b0;
      end
      // A request in the same cycle stays pending for the following frame.
      if (sel_ok) begin
        pend_sel <= sel_code;
        pend_vld <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tint_level.sv
module tint_level #(
  parameter int BRT_W = 10,
  parameter int OUT_W = 5
) (
  input  logic [1:0]       pix_code,
  input  logic [BRT_W-1:0] brt,
  output logic [OUT_W-1:0] lvl,
  output logic             lit,
  output logic             full
);
  import tint_pkg::*;

  function automatic logic [BRT_W-1:0] intensity_of(input logic [1:0] c,
                                                    input logic [BRT_W-1:0] b);
    case (pix_code_e'(c))
      PIX_FULL:             return b;
      PIX_DIM_A, PIX_DIM_B: return b >> 1;
      default:              return '0;
    endcase
  endfunction

  logic [BRT_W-1:0] inten;

  assign inten = intensity_of(pix_code, brt);
  assign lvl   = inten[BRT_W-1 -: OUT_W];
  assign lit   = (pix_code != PIX_BLACK);
  assign full  = (pix_code == PIX_FULL);

endmodule

// File: rtl/tint_chan.sv
module tint_chan #(
  parameter int OUT_W = 5
) (
  input  logic [OUT_W-1:0] lvl,
  input  logic             lit,
  input  logic             full,
  input  logic             en_dim,
  input  logic             en_full,
  output logic [OUT_W-1:0] val
);

  logic en;

  assign en  = lit && (full ? en_full : en_dim);
  assign val = en ? lvl : '0;

endmodule

// File: rtl/pix_tint_mapper.sv
module pix_tint_mapper #(
  parameter int BRT_W       = 10,
  parameter int LVL_STEPS   = 32,
  parameter int NUM_SCHEMES = 6,
  parameter int OUT_W       = $clog2(LVL_STEPS),
  parameter int SEL_W       = $clog2(NUM_SCHEMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       pix_code,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic [BRT_W-1:0] brightness,
  input  logic             sel_stb,
  input  logic [SEL_W-1:0] sel_code,
  output logic             hsync_out,
  output logic             vsync_out,
  output logic [OUT_W-1:0] red,
  output logic [OUT_W-1:0] grn,
  output logic [OUT_W-1:0] blu
);
  import tint_pkg::*;

  logic             frame_start;
  logic             sched_apply;
  logic [SEL_W-1:0] cur_scheme;
  logic [BRT_W-1:0] brt_q;
  logic [OUT_W-1:0] lvl;
  logic             lit;
  logic             full;
  ch_mask_t         mask_dim;
  ch_mask_t         mask_full;
  logic [OUT_W-1:0] chan_val [NUM_CH];

  tint_frame_sched #(
    .BRT_W(BRT_W), .NUM_SCHEMES(NUM_SCHEMES), .SEL_W(SEL_W)
  ) u_sched (
    .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .brightness(brightness),
    .sel_stb(sel_stb), .sel_code(sel_code), .frame_start(frame_start),
    .sched_apply(sched_apply), .cur_scheme(cur_scheme), .brt_q(brt_q)
  );

  tint_level #(.BRT_W(BRT_W), .OUT_W(OUT_W)) u_level (
    .pix_code(pix_code), .brt(brt_q), .lvl(lvl), .lit(lit), .full(full)
  );

  assign mask_dim  = scheme_mask(32'(cur_scheme), 1'b0);
  assign mask_full = scheme_mask(32'(cur_scheme), 1'b1);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    tint_chan #(.OUT_W(OUT_W)) u_chan (
      .lvl(lvl), .lit(lit), .full(full),
      .en_dim(mask_dim[ch]), .en_full(mask_full[ch]), .val(chan_val[ch])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_out <= 1'b0;
      vsync_out <= 1'b0;
      red       <= '0;
      grn       <= '0;
      blu       <= '0;
    end else begin
      hsync_out <= hsync_in;
      vsync_out <= vsync_in;
      red       <= chan_val[CH_RED];
      grn       <= chan_val[CH_GRN];
      blu       <= chan_val[CH_BLU];
    end
  end

endmodule

// File: rtl/pix_tint_mapper_chk.sv
module pix_tint_mapper_chk #(
  parameter int BRT_W       = 10,
  parameter int NUM_SCHEMES = 6,
  parameter int OUT_W       = 5,
  parameter int SEL_W       = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       pix_code,
  input logic             hsync_in,
  input logic             vsync_in,
  input logic             hsync_out,
  input logic             vsync_out,
  input logic [OUT_W-1:0] red,
  input logic [OUT_W-1:0] grn,
  input logic [OUT_W-1:0] blu,
  input logic             frame_start,
  input logic             sched_apply,
  input logic [SEL_W-1:0] cur_scheme,
  input logic [BRT_W-1:0] brt_q
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_black_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(pix_code) == 2'b00) |-> (red == '0 && grn == '0 && blu == '0));

  p_sync_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (hsync_out == $past(hsync_in) && vsync_out == $past(vsync_in)));

  p_brt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(brt_q));

  p_scheme_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sched_apply |=> $stable(cur_scheme));

  p_apply_at_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sched_apply |-> (vsync_in && frame_start));

  p_valid_scheme_r8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cur_scheme) < NUM_SCHEMES);

endmodule

bind pix_tint_mapper pix_tint_mapper_chk #(
  .BRT_W(BRT_W), .NUM_SCHEMES(NUM_SCHEMES), .OUT_W(OUT_W), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_code(pix_code), .hsync_in(hsync_in),
  .vsync_in(vsync_in), .hsync_out(hsync_out), .vsync_out(vsync_out),
  .red(red), .grn(grn), .blu(blu), .frame_start(frame_start),
  .sched_apply(sched_apply), .cur_scheme(cur_scheme), .brt_q(brt_q)
);

// File: tb/pix_tint_mapper_bench.sv
`timescale 1ns/1ps
module pix_tint_mapper_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pix = 2'b00;
  logic       hs = 1'b0, vs = 1'b0, stb = 1'b0;
  logic [9:0] brt = '0;
  logic [2:0] sel = '0;
  logic       hso, vso, hso16, vso16;
  logic [4:0] r5, g5, b5;
  logic [3:0] r4, g4, b4;
  int checks = 0;
  int failures = 0;
  int cur_s = 0;
  int cur_b = 0;

  always #2 clk = ~clk;

  pix_tint_mapper u_pix_tint_mapper (
    .clk(clk), .rst_n(rst_n), .pix_code(pix), .hsync_in(hs), .vsync_in(vs),
    .brightness(brt), .sel_stb(stb), .sel_code(sel),
    .hsync_out(hso), .vsync_out(vso), .red(r5), .grn(g5), .blu(b5));

  pix_tint_mapper #(.LVL_STEPS(16)) u_pix_tint_mapper_s16 (
    .clk(clk), .rst_n(rst_n), .pix_code(pix), .hsync_in(hs), .vsync_in(vs),
    .brightness(brt), .sel_stb(stb), .sel_code(sel),
    .hsync_out(hso16), .vsync_out(vso16), .red(r4), .grn(g4), .blu(b4));

  // {scheme[29:27], brightness[26:17], code[16:15], r[14:10], g[9:5], b[4:0]} at 32 steps
  localparam logic [29:0] VEC [15] = '{
    {3'd0, 10'd1023, 2'b11, 5'd0,  5'd31, 5'd0},
    {3'd0, 10'd1023, 2'b01, 5'd0,  5'd15, 5'd0},
    {3'd0, 10'd1023, 2'b10, 5'd0,  5'd15, 5'd0},
    {3'd0, 10'd1023, 2'b00, 5'd0,  5'd0,  5'd0},
    {3'd1, 10'd640,  2'b11, 5'd20, 5'd20, 5'd20},
    {3'd1, 10'd640,  2'b01, 5'd10, 5'd10, 5'd10},
    {3'd2, 10'd100,  2'b11, 5'd3,  5'd3,  5'd0},
    {3'd3, 10'd1000, 2'b01, 5'd0,  5'd0,  5'd15},
    {3'd3, 10'd1000, 2'b11, 5'd31, 5'd31, 5'd31},
    {3'd4, 10'd33,   2'b11, 5'd1,  5'd1,  5'd0},
    {3'd4, 10'd33,   2'b01, 5'd0,  5'd0,  5'd0},
    {3'd4, 10'd512,  2'b01, 5'd0,  5'd8,  5'd0},
    {3'd5, 10'd777,  2'b01, 5'd0,  5'd12, 5'd12},
    {3'd5, 10'd777,  2'b11, 5'd24, 5'd0,  5'd24},
    {3'd5, 10'd31,   2'b11, 5'd0,  5'd0,  5'd0}
  };

  task automatic step(input logic [1:0] c, input logic h, input logic v, input logic s);
    @(negedge clk);
    pix = c; hs = h; vs = v; stb = s;
    @(posedge clk);
    #1;
  endtask

  task automatic frame();
    step(2'b00, 1'b0, 1'b1, 1'b0);
    step(2'b00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic request(input int s);
    sel = 3'(s);
    step(2'b00, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic expect_rgb(input string req, input int er, input int eg, input int eb);
    checks++;
    if (r5 != 5'(er) || g5 != 5'(eg) || b5 != 5'(eb) ||
        r4 != 4'(er >> 1) || g4 != 4'(eg >> 1) || b4 != 4'(eb >> 1)) begin
      failures++;
      $display("FAIL %s: got 32-step (%0d,%0d,%0d) 16-step (%0d,%0d,%0d) expected (%0d,%0d,%0d)/(%0d,%0d,%0d)",
               req, r5, g5, b5, r4, g4, b4, er, eg, eb, er >> 1, eg >> 1, eb >> 1);
    end
  endtask

  task automatic expect_sync(input string req, input logic eh, input logic ev);
    checks++;
    if (hso != eh || vso != ev || hso16 != eh || vso16 != ev) begin
      failures++;
      $display("FAIL %s: got hsync=%0b vsync=%0b expected hsync=%0b vsync=%0b",
               req, hso, vso, eh, ev);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    expect_rgb("R9 outputs during reset", 0, 0, 0);
    expect_sync("R9 syncs during reset", 1'b0, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    // R9: brightness starts at zero, so a full pixel stays black
    brt = 10'd1023;
    step(2'b11, 1'b0, 1'b0, 1'b0);
    expect_rgb("R9 black before first frame", 0, 0, 0);
    // R9: scheme 0 active after reset
    frame();
    step(2'b11, 1'b0, 1'b0, 1'b0);
    expect_rgb("R9 scheme 0 after reset", 0, 31, 0);
    cur_b = 1023;

    // R5: syncs delayed one cycle with the pixel
    step(2'b11, 1'b1, 1'b0, 1'b0);
    expect_sync("R5 hsync one-cycle delay", 1'b1, 1'b0);
    step(2'b11, 1'b0, 1'b1, 1'b0);
    expect_sync("R5 vsync one-cycle delay", 1'b0, 1'b1);
    expect_rgb("R5 pixel aligned with syncs", 0, 31, 0);
    step(2'b00, 1'b0, 1'b0, 1'b0);

    // R1 R2 R3 R4 R10: vector table
    for (int i = 0; i < 15; i++) begin
      if (int'(VEC[i][29:27]) != cur_s) begin
        request(int'(VEC[i][29:27]));
        cur_s = int'(VEC[i][29:27]);
      end
      if (int'(VEC[i][26:17]) != cur_b || i == 0) begin
        brt = VEC[i][26:17];
        frame();
        cur_b = int'(VEC[i][26:17]);
      end
      step(VEC[i][16:15], 1'b0, 1'b0, 1'b0);
      expect_rgb($sformatf("R1/R2/R3/R4/R10 vector %0d", i),
                 int'(VEC[i][14:10]), int'(VEC[i][9:5]), int'(VEC[i][4:0]));
    end

    // R6: brightness captured only on the vsync rising cycle
    brt = 10'd1023;
    frame();
    step(2'b11, 1'b0, 1'b0, 1'b0);
    expect_rgb("R6 scheme 5 full", 31, 0, 31);
    brt = 10'd64;
    step(2'b11, 1'b0, 1'b0, 1'b0);
    expect_rgb("R6 mid-frame brightness ignored", 31, 0, 31);
    brt = 10'd1023;
    step(2'b00, 1'b0, 1'b1, 1'b0);
    brt = 10'd64;
    step(2'b00, 1'b0, 1'b1, 1'b0);
    step(2'b11, 1'b0, 1'b1, 1'b0);
    expect_rgb("R6 brightness ignored while vsync stays high", 31, 0, 31);
    step(2'b00, 1'b0, 1'b0, 1'b0);
    brt = 10'd1023;

    // R7: request waits for frame start
    request(1);
    step(2'b11, 1'b0, 1'b0, 1'b0);
    expect_rgb("R7 scheme unchanged before frame", 31, 0, 31);
    frame();
    step(2'b11, 1'b0, 1'b0, 1'b0);
    expect_rgb("R7 scheme 1 after frame", 31, 31, 31);

    // R7: strobe in the frame-start cycle waits one more frame
    sel = 3'd2;
    step(2'b00, 1'b0, 1'b1, 1'b1);
    step(2'b11, 1'b0, 1'b0, 1'b0);
    expect_rgb("R7 same-cycle strobe deferred", 31, 31, 31);
    frame();
    step(2'b11, 1'b0, 1'b0, 1'b0);
    expect_rgb("R7 deferred strobe applied", 31, 31, 0);

    // R7: a later request replaces an earlier one
    request(3);
    request(4);
    frame();
    step(2'b01, 1'b0, 1'b0, 1'b0);
    expect_rgb("R7 latest request wins", 0, 15, 0);

    // R8: out-of-range codes ignored
    request(7);
    frame();
    step(2'b11, 1'b0, 1'b0, 1'b0);
    expect_rgb("R8 code 7 ignored", 31, 31, 0);
    request(0);
    request(6);
    frame();
    step(2'b11, 1'b0, 1'b0, 1'b0);
    expect_rgb("R8 code 6 ignored, earlier request kept", 0, 31, 0);
    step(2'b00, 1'b0, 1'b0, 1'b0);
    expect_rgb("R1 black after full", 0, 0, 0);

    summary();
  end

endmodule